// File: doc/BRIEF.md
# Digital Potentiometer Command Engine

This block executes the command layer of a serially controlled 64-position potentiometer. A bus front end detects start and stop conditions, matches the slave address and shifts bytes. It passes events to this engine. Those events are a frame-open pulse, one strobe per received byte after the address, a frame-close pulse, and one pulse per serial-clock rising edge together with the data-line level. The engine decodes the instruction byte and returns an acknowledge decision for every byte. For read commands it supplies the byte to send back. It keeps the 6-bit wiper position and four 6-bit stored settings.

Changes to stored settings are modelled as a slow nonvolatile write. A write is only queued during the frame. Its busy period starts when the frame closes and lasts a fixed number of system clocks. The new value lands when that period ends. While the engine is busy it refuses every byte, which lets a host poll for completion. A write-protect input, active low, turns stored writes into harmless no-ops. A reset reloads the wiper from stored setting 0, and the stored settings survive the reset.

Top module: `pot_cmd_engine`

## Requirements
- R1: An instruction byte is accepted (ack_ok=1) only when bits [1:0] are 00 and bits [7:4] hold one of 1001, 1010, 1011, 1100, 1101, 1110 or 0010. Any other instruction byte gets ack_ok=0 and changes neither the wiper nor any stored setting.
- R2: Opcode 1010 takes the next byte and loads its bits [5:0] into the wiper. Opcode 1001 returns {2'b00, wiper} on tx_byte.
- R3: Opcode 1011 returns {2'b00, stored[sel]} on tx_byte, where sel is instruction bits [3:2].
- R4: Opcode 1100 takes a data byte and queues bits [5:0] for stored[sel]. busy rises in the cycle after frame_stop and stays high for BUSY_CYC cycles. The stored value is only updated when busy falls.
- R5: Opcode 1101 copies stored[sel] into the wiper at once. Opcode 1110 queues the wiper value for stored[sel], with the same deferred commit as R4.
- R6: After opcode 0010, each scl_rise pulse with sda_lvl=1 moves the wiper up one step and each pulse with sda_lvl=0 moves it down one step. The wiper saturates at 0 and 63. The mode lasts until frame_stop.
- R7: With wr_prot_n=0, stored-setting writes still acknowledge their bytes, but no busy period starts and the stored setting is not changed.
- R8: While busy=1, received bytes get ack_ok=0, the wiper holds its value and no command executes.
- R9: Reset loads the wiper from stored[0]. Stored settings keep their contents across reset.
- R10: ack_vld and ack_ok, and tx_byte for reads, are registered. They are valid in the cycle after rx_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Pulse: start condition seen and address matched |
| frame_stop | input | 1 | Pulse: stop condition seen |
| rx_valid | input | 1 | Pulse: a command or data byte has been received |
| rx_byte | input | 8 | Received byte |
| scl_rise | input | 1 | Pulse per serial-clock rising edge while stepping |
| sda_lvl | input | 1 | Data-line level sampled with scl_rise |
| wr_prot_n | input | 1 | Low blocks stored-setting writes |
| ack_vld | output | 1 | Acknowledge decision valid |
| ack_ok | output | 1 | 1 = acknowledge the byte |
| tx_byte | output | 8 | Byte to send back for read commands |
| busy | output | 1 | Nonvolatile write period in progress |
| wiper | output | 6 | Current wiper position |

## Verification
The assertions check several properties on every cycle. The wiper moves by at most one step on a stepping pulse. It never wraps past either end. It holds still without a load or a step, and it stays frozen while busy. Any byte received during busy is refused. busy only rises after a queued write, and it ends through the timer's completion cycle.

Only the bench scenarios can show that each opcode reaches the right register with the right data. The same holds for the write-protect path, which acknowledges its bytes but leaves storage untouched. Two more scenarios need the bench: a stored value appears only after the busy period, and a reset recalls stored setting 0 into the wiper.

// File: rtl/potc_pkg.sv
package potc_pkg;
  localparam logic [3:0] OP_STEP   = 4'b0010;
  localparam logic [3:0] OP_RD_WIP = 4'b1001;
  localparam logic [3:0] OP_WR_WIP = 4'b1010;
  localparam logic [3:0] OP_RD_REG = 4'b1011;
  localparam logic [3:0] OP_WR_REG = 4'b1100;
  localparam logic [3:0] OP_LD_WIP = 4'b1101;
  localparam logic [3:0] OP_SV_WIP = 4'b1110;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CMD,
    ST_DATA,
    ST_STEP
  } eng_st_e;
endpackage

// File: rtl/pot_busy_timer.sv
module pot_busy_timer #(
  parameter int BUSY_CYC = 625000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(BUSY_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(BUSY_CYC);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (start && cnt == '0) cnt <= LOAD;
    else if (cnt != '0) cnt <= cnt - ONE;
  end

  assign busy = (cnt != '0);
  assign done = (cnt == ONE);

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy); // R4
  AST_END_VIA_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(done)); // R4
endmodule

// File: rtl/pot_store.sv
module pot_store #(
  parameter int NREG = 4,
  parameter int W    = 6
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] waddr,
  input  logic [W-1:0]            wdata,
  input  logic [$clog2(NREG)-1:0] raddr,
  output logic [W-1:0]            rdata,
  output logic [W-1:0]            rd0
);
  logic [W-1:0] mem [NREG];

  initial begin
    for (int i = 0; i < NREG; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
  assign rd0   = mem[0];
endmodule

// File: rtl/pot_wiper.sv
module pot_wiper #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] recall_val,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         step,
  input  logic         up,
  output logic [W-1:0] wip
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (rst) wip <= recall_val;
    else if (ld) wip <= ld_val;
    else if (step) begin
      if (up && wip != TOP) wip <= wip + ONE;
      else if (!up && wip != '0) wip <= wip - ONE;
    end
  end

  AST_SAT_TOP: assert property (@(posedge clk) disable iff (rst)
    (step && !ld && up && wip == TOP) |=> wip == TOP); // R6
  AST_SAT_BOT: assert property (@(posedge clk) disable iff (rst)
    (step && !ld && !up && wip == '0) |=> wip == '0); // R6
  AST_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
    (step && !ld) |=> (wip == $past(wip) || wip == $past(wip) + ONE
                       || wip == $past(wip) - ONE)); // R6
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!step && !ld) |=> $stable(wip)); // R1
endmodule

// File: rtl/pot_cmd_engine.sv
module pot_cmd_engine
  import potc_pkg::*;
#(
  parameter int NREG     = 4,
  parameter int W        = 6,
  parameter int BUSY_CYC = 625000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         frame_start,
  input  logic         frame_stop,
  input  logic         rx_valid,
  input  logic [7:0]   rx_byte,
  input  logic         scl_rise,
  input  logic         sda_lvl,
  input  logic         wr_prot_n,
  output logic         ack_vld,
  output logic         ack_ok,
  output logic [7:0]   tx_byte,
  output logic         busy,
  output logic [W-1:0] wiper
);
  localparam int SW = $clog2(NREG);
  localparam int PADW = 8 - W;

  eng_st_e        st;
  logic [3:0]     op_q;
  logic [SW-1:0]  sel_q;
  logic           pend;
  logic [SW-1:0]  pend_sel;
  logic [W-1:0]   pend_val;
  logic           t_done;
  logic [W-1:0]   st_rdata, st_rd0;
  logic           w_ld, w_step;
  logic [W-1:0]   w_ld_val;

  wire [3:0]    in_op  = rx_byte[7:4];
  wire [SW-1:0] in_sel = rx_byte[2 +: SW];
  wire          lo_ok  = (rx_byte[1:0] == 2'b00);
  wire          op_ok  = lo_ok && (in_op == OP_STEP || in_op == OP_RD_WIP ||
                          in_op == OP_WR_WIP || in_op == OP_RD_REG ||
                          in_op == OP_WR_REG || in_op == OP_LD_WIP ||
                          in_op == OP_SV_WIP);
  wire cmd_go  = rx_valid && !busy && st == ST_CMD && op_ok;
  wire data_go = rx_valid && !busy && st == ST_DATA;

  pot_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_timer (
    .clk(clk), .rst(rst), .start(frame_stop && pend && !busy),
    .busy(busy), .done(t_done));

  pot_store #(.NREG(NREG), .W(W)) u_store (
    .clk(clk), .we(t_done), .waddr(pend_sel), .wdata(pend_val),
    .raddr(in_sel), .rdata(st_rdata), .rd0(st_rd0));

  always_comb begin
    w_ld     = 1'b0;
    w_ld_val = rx_byte[W-1:0];
    if (cmd_go && in_op == OP_LD_WIP) begin
      w_ld     = 1'b1;
      w_ld_val = st_rdata;
    end else if (data_go && op_q == OP_WR_WIP) begin
      w_ld     = 1'b1;
    end
  end
  assign w_step = scl_rise && st == ST_STEP && !busy;

  pot_wiper #(.W(W)) u_wiper (
    .clk(clk), .rst(rst), .recall_val(st_rd0), .ld(w_ld),
    .ld_val(w_ld_val), .step(w_step), .up(sda_lvl), .wip(wiper));

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      op_q     <= '0;
      sel_q    <= '0;
      pend     <= 1'b0;
      pend_sel <= '0;
      pend_val <= '0;
      ack_vld  <= 1'b0;
      ack_ok   <= 1'b0;
      tx_byte  <= '0;
    end else begin
      ack_vld <= rx_valid;
      ack_ok  <= 1'b0;
      if (frame_stop) begin
        st   <= ST_IDLE;
        pend <= 1'b0;
      end else if (frame_start && !busy) begin
        st <= ST_CMD;
      end else if (cmd_go) begin
        ack_ok <= 1'b1;
        op_q   <= in_op;
        sel_q  <= in_sel;
        st     <= ST_IDLE;
        case (in_op)
          OP_RD_WIP: tx_byte <= {{PADW{1'b0}}, wiper};
          OP_RD_REG: tx_byte <= {{PADW{1'b0}}, st_rdata};
          OP_WR_WIP, OP_WR_REG: st <= ST_DATA;
          OP_STEP: st <= ST_STEP;
          OP_SV_WIP: if (wr_prot_n) begin
            pend     <= 1'b1;
            pend_sel <= in_sel;
            pend_val <= wiper;
          end
          default: ;
        endcase
      end else if (data_go) begin
        ack_ok <= 1'b1;
        st     <= ST_IDLE;
        if (op_q == OP_WR_REG && wr_prot_n) begin
          pend     <= 1'b1;
          pend_sel <= sel_q;
          pend_val <= rx_byte[W-1:0];
        end
      end else if (rx_valid) begin
        st <= ST_IDLE;
      end
    end
  end

  AST_BUSY_NACK: assert property (@(posedge clk) disable iff (rst)
    (busy && rx_valid) |=> !ack_ok); // R8
  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(wiper)); // R8
  AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(pend && frame_stop)); // R4
  AST_ACK_PAIR: assert property (@(posedge clk) disable iff (rst)
    ack_ok |-> ack_vld); // R10
endmodule

// File: tb/pot_cmd_engine_tb_top.sv
module pot_cmd_engine_tb_top;
  localparam int BC = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_start = 0, frame_stop = 0, rx_valid = 0, scl_rise = 0, sda_lvl = 0;
  logic wr_prot_n = 1;
  logic [7:0] rx_byte = '0;
  logic ack_vld, ack_ok, busy;
  logic [7:0] tx_byte;
  logic [5:0] wiper;

  int total = 0;
  int bad = 0;

  typedef struct {
    logic       ack;
    logic       has_tx;
    logic [7:0] tx;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  pot_cmd_engine #(.NREG(4), .W(6), .BUSY_CYC(BC)) dut_i (
    .clk(clk), .rst(rst), .frame_start(frame_start), .frame_stop(frame_stop),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .scl_rise(scl_rise),
    .sda_lvl(sda_lvl), .wr_prot_n(wr_prot_n), .ack_vld(ack_vld),
    .ack_ok(ack_ok), .tx_byte(tx_byte), .busy(busy), .wiper(wiper));

  always @(negedge clk) begin
    if (!rst && ack_vld) begin
      total++;
      if (q.size() == 0) begin
        bad++;
        $display("FAIL R10 unexpected ack_vld act=%0b exp=none", ack_ok);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (ack_ok !== e.ack || (e.has_tx && tx_byte !== e.tx)) begin
          bad++;
          $display("FAIL %s ack act=%0b exp=%0b tx act=%02h exp=%02h",
                   e.tag, ack_ok, e.ack, tx_byte, e.tx);
        end
      end
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  task automatic fstart();
    @(negedge clk) frame_start = 1;
    @(negedge clk) frame_start = 0;
  endtask

  task automatic fstop();
    @(negedge clk) frame_stop = 1;
    @(negedge clk) frame_stop = 0;
  endtask

  task automatic sbyte(logic [7:0] b, logic ack, logic has_tx, logic [7:0] tx, string tag);
    exp_t e;
    e.ack = ack; e.has_tx = has_tx; e.tx = tx; e.tag = tag;
    q.push_back(e);
    @(negedge clk) begin rx_valid = 1; rx_byte = b; end
    @(negedge clk) rx_valid = 0;
  endtask

  task automatic step(logic lvl);
    @(negedge clk) begin scl_rise = 1; sda_lvl = lvl; end
    @(negedge clk) scl_rise = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4 * BC && busy; i++) @(negedge clk);
  endtask

  task automatic set_wip(logic [5:0] v, string tag);
    fstart(); sbyte(8'hA0, 1, 0, 0, tag); sbyte({2'b00, v}, 1, 0, 0, tag); fstop();
  endtask

  task automatic rd_reg(int s, logic [5:0] v, string tag);
    fstart(); sbyte(8'hB0 | (s << 2), 1, 1, {2'b00, v}, tag); fstop();
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R9 reset wiper", {2'b0, wiper}, 8'h00);
    chk("R4 reset busy", {7'b0, busy}, 8'h00);

    set_wip(6'h15, "R2 write wiper");
    chk("R2 wiper after write", {2'b0, wiper}, 8'h15);
    fstart(); sbyte(8'h90, 1, 1, 8'h15, "R2 read wiper"); fstop();

    // R4 stored write with deferred commit
    fstart(); sbyte(8'hC8, 1, 0, 0, "R4 wr reg2 cmd"); sbyte(8'h2A, 1, 0, 0, "R4 wr reg2 data");
    chk("R4 busy before stop", {7'b0, busy}, 8'h00);
    fstop();
    chk("R4 busy after stop", {7'b0, busy}, 8'h01);
    // R8 refused while busy
    fstart(); sbyte(8'hB8, 0, 0, 0, "R8 nack while busy"); sbyte(8'hA0, 0, 0, 0, "R8 nack2"); fstop();
    chk("R8 wiper frozen", {2'b0, wiper}, 8'h15);
    wait_idle();
    chk("R4 busy ended", {7'b0, busy}, 8'h00);
    rd_reg(2, 6'h2A, "R3 R4 read reg2");

    fstart(); sbyte(8'hD8, 1, 0, 0, "R5 load from reg2"); fstop();
    chk("R5 wiper loaded", {2'b0, wiper}, 8'h2A);

    fstart(); sbyte(8'h20, 1, 0, 0, "R6 step cmd");
    step(1); step(1); step(1);
    chk("R6 up x3", {2'b0, wiper}, 8'h2D);
    step(0); step(0);
    chk("R6 down x2", {2'b0, wiper}, 8'h2B);
    fstop();
    step(1);
    chk("R6 no step after stop", {2'b0, wiper}, 8'h2B);

    set_wip(6'h3E, "R6 preset high");
    fstart(); sbyte(8'h20, 1, 0, 0, "R6 step cmd2");
    step(1); step(1); step(1);
    chk("R6 saturate top", {2'b0, wiper}, 8'h3F);
    fstop();
    set_wip(6'h01, "R6 preset low");
    fstart(); sbyte(8'h20, 1, 0, 0, "R6 step cmd3");
    step(0); step(0); step(0);
    chk("R6 saturate bottom", {2'b0, wiper}, 8'h00);
    fstop();

    // R7 write protect
    wr_prot_n = 0;
    fstart(); sbyte(8'hC4, 1, 0, 0, "R7 wp cmd"); sbyte(8'h11, 1, 0, 0, "R7 wp data"); fstop();
    chk("R7 no busy", {7'b0, busy}, 8'h00);
    fstart(); sbyte(8'hE4, 1, 0, 0, "R7 wp save"); fstop();
    chk("R7 no busy save", {7'b0, busy}, 8'h00);
    wr_prot_n = 1;
    rd_reg(1, 6'h00, "R7 reg1 unchanged");

    set_wip(6'h07, "R5 preset");
    fstart(); sbyte(8'hEC, 1, 0, 0, "R5 save to reg3"); fstop();
    chk("R5 save busy", {7'b0, busy}, 8'h01);
    wait_idle();
    rd_reg(3, 6'h07, "R5 read reg3");

    // R1 invalid instructions
    fstart(); sbyte(8'hF0, 0, 0, 0, "R1 bad opcode"); fstop();
    fstart(); sbyte(8'hD9, 0, 0, 0, "R1 low bits set"); fstop();
    fstart(); sbyte(8'hC1, 0, 0, 0, "R1 bad wr reg"); sbyte(8'h3F, 0, 0, 0, "R1 no data"); fstop();
    chk("R1 wiper unchanged", {2'b0, wiper}, 8'h07);
    chk("R1 no busy", {7'b0, busy}, 8'h00);
    rd_reg(0, 6'h00, "R1 reg0 unchanged");

    // R9 recall
    fstart(); sbyte(8'hC0, 1, 0, 0, "R9 wr reg0"); sbyte(8'h33, 1, 0, 0, "R9 data"); fstop();
    wait_idle();
    @(negedge clk) rst = 1;
    @(negedge clk) rst = 0;
    chk("R9 recall reg0", {2'b0, wiper}, 8'h33);
    rd_reg(2, 6'h2A, "R9 reg2 kept");

    repeat (3) @(negedge clk);
    total++;
    if (q.size() != 0) begin
      bad++;
      $display("FAIL R10 missing acks act=%0d exp=0", q.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule